// File: doc/BRIEF.md
# Performance Counter Bank with Overflow Control

This block holds eight event counters, each 48 bits wide. Three enables must all be set for a counter to advance by one on a clock edge: an upper-level enable pin, that counter's bit in a bank-wide enable register, and the enable bit in the counter's own control register. The control register also selects which of eight single-bit event lines the counter samples.

A counter that steps from all-ones wraps to zero and sets its bit in a sticky overflow status register. Status bits are cleared only through a separate write-1-to-clear register. A per-counter interrupt-enable bit decides whether that counter's status bit drives the shared interrupt output. All state is reached through a flat register port with an address, a write strobe and a combinational read path.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every counter, every control register, the bank enable register and the overflow status register read 0, and `irq_o` is low.
- R2: On a clock edge, a counter increments by exactly one only when `up_en_i` is 1, its bank enable bit (address 0, bit i for counter i) is 1, its control enable bit (bit 0) is 1, and its selected event line is 1. Otherwise it holds its value.
- R3: Control bits [3:1] pick the event line: value s makes the counter sample `evt_i[s]`. Activity on the other lines has no effect.
- R4: An increment from all-ones wraps the counter to 0 and sets status bit i (address 1) on the same edge.
- R5: Writing the clear register (address 2) clears every status bit written as 1. Bits written as 0 leave status unchanged, and reading address 2 returns 0.
- R6: If an overflow and a clear of the same status bit fall on the same edge, the bit stays set.
- R7: `irq_o` is high exactly when some counter has both its status bit and its control interrupt-enable bit (bit 4) set.
- R8: Counter i is read and written at address 16+i, and control register i at address 8+i. A counter write takes priority over an increment on the same edge. Writes to the status register at address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_en_i | input | 1 | Upper-level counting enable |
| evt_i | input | 8 | Event lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 48 | Register write data |
| reg_rdata_o | output | 48 | Register read data (combinational) |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions expect the register port to present a stable address and write strobe around each clock edge, and they expect a write of a counter to override any increment on that edge. The hold property ignores the event line, so a counter with all three enables set is treated as free to move. The stimulus changes every input only on falling edges. It keeps the event lines low while it reconfigures a counter, so the only counting that happens is inside the cycle windows the bench chooses. Counters are preloaded near all-ones by direct writes, so each wrap is reached in a few cycles.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  // control register layout: enable, event select, interrupt enable
  localparam int CTL_EN_BIT = 0;
  localparam int CTL_SEL_LSB = 1;

  // register map
  localparam int ADR_GLOBAL_EN = 0;
  localparam int ADR_STATUS    = 1;
  localparam int ADR_CLEAR     = 2;
  localparam int ADR_CTL_BASE  = 8;
  localparam int ADR_CNT_BASE  = 16;
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int CTR_W   = 48,
  parameter int NUM_EVT = 8,
  localparam int SEL_W  = $clog2(NUM_EVT),
  localparam int CTL_W  = SEL_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_en_i,
  input  logic               glob_en_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               ctl_we_i,
  input  logic               cnt_we_i,
  input  logic [CTR_W-1:0]   wdata_i,
  output logic [CTL_W-1:0]   ctl_o,
  output logic [CTR_W-1:0]   cnt_o,
  output logic               ie_o,
  output logic               ovf_o
);
  import pmc_pkg::*;

  localparam logic [CTR_W-1:0] ALL_ONES = {CTR_W{1'b1}};

  function automatic logic [CTR_W-1:0] step(input logic [CTR_W-1:0] v);
    return v + CTR_W'(1);
  endfunction

  logic [CTL_W-1:0] ctl_q;
  logic [CTR_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel;
  logic             ctl_en;
  logic             enabled;
  logic             inc;

  assign sel     = ctl_q[CTL_SEL_LSB +: SEL_W];
  assign ctl_en  = ctl_q[CTL_EN_BIT];
  assign enabled = up_en_i & glob_en_i & ctl_en;
  assign inc     = enabled & evt_i[sel] & ~cnt_we_i;
  assign ovf_o   = inc & (cnt_q == ALL_ONES);
  assign ctl_o   = ctl_q;
  assign cnt_o   = cnt_q;
  assign ie_o    = ctl_q[CTL_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ctl_we_i) ctl_q <= wdata_i[CTL_W-1:0];
      if (cnt_we_i)  cnt_q <= wdata_i;
      else if (inc)  cnt_q <= step(cnt_q);
    end
  end

  // R2
  hold_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we_i && !enabled) |=> (cnt_q == $past(cnt_q)));

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == '0));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/pmc_status.sv
module pmc_status #(
  parameter int NUM_CTR = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] ovf_i,
  input  logic               clr_we_i,
  input  logic [NUM_CTR-1:0] clr_mask_i,
  input  logic [NUM_CTR-1:0] ie_i,
  output logic [NUM_CTR-1:0] status_o,
  output logic               irq_o
);
  logic [NUM_CTR-1:0] status_q;
  logic [NUM_CTR-1:0] clr_eff;

  assign clr_eff  = clr_we_i ? clr_mask_i : '0;
  assign status_o = status_q;
  assign irq_o    = |(status_q & ie_i);

  // overflow is ORed in after the clear, so it wins a same-edge race
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_eff) | ovf_i;
  end

  // R4
  ovf_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i != '0) |=> ((status_q & $past(ovf_i)) == $past(ovf_i)));

  // R5
  clear_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((status_q & $past(clr_mask_i & ~ovf_i)) == '0));

  // R5
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i == '0) |=> ((status_q & ~$past(status_q)) == '0));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq_o);
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 48,
  parameter int NUM_EVT = 8,
  parameter int ADDR_W  = 5,
  localparam int SEL_W  = $clog2(NUM_EVT),
  localparam int CTL_W  = SEL_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_en_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [CTR_W-1:0]   reg_wdata_i,
  output logic [CTR_W-1:0]   reg_rdata_o,
  output logic               irq_o
);
  import pmc_pkg::*;

  logic [NUM_CTR-1:0] glob_en_q;
  logic [NUM_CTR-1:0] ovf_vec;
  logic [NUM_CTR-1:0] ie_vec;
  logic [NUM_CTR-1:0] status;
  logic [CTL_W-1:0]   ctl_arr [NUM_CTR];
  logic [CTR_W-1:0]   cnt_arr [NUM_CTR];
  logic               clr_we;

  assign clr_we = reg_we_i && (reg_addr_i == ADDR_W'(ADR_CLEAR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glob_en_q <= '0;
    else if (reg_we_i && reg_addr_i == ADDR_W'(ADR_GLOBAL_EN))
      glob_en_q <= reg_wdata_i[NUM_CTR-1:0];
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic ctl_we, cnt_we;
    assign ctl_we = reg_we_i && (reg_addr_i == ADDR_W'(ADR_CTL_BASE + i));
    assign cnt_we = reg_we_i && (reg_addr_i == ADDR_W'(ADR_CNT_BASE + i));
    pmc_counter #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_en_i  (up_en_i),
      .glob_en_i(glob_en_q[i]),
      .evt_i    (evt_i),
      .ctl_we_i (ctl_we),
      .cnt_we_i (cnt_we),
      .wdata_i  (reg_wdata_i),
      .ctl_o    (ctl_arr[i]),
      .cnt_o    (cnt_arr[i]),
      .ie_o     (ie_vec[i]),
      .ovf_o    (ovf_vec[i])
    );
  end

  pmc_status #(.NUM_CTR(NUM_CTR)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf_i     (ovf_vec),
    .clr_we_i  (clr_we),
    .clr_mask_i(reg_wdata_i[NUM_CTR-1:0]),
    .ie_i      (ie_vec),
    .status_o  (status),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADR_GLOBAL_EN)) reg_rdata_o = CTR_W'(glob_en_q);
    if (reg_addr_i == ADDR_W'(ADR_STATUS))    reg_rdata_o = CTR_W'(status);
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr_i == ADDR_W'(ADR_CTL_BASE + i)) reg_rdata_o = CTR_W'(ctl_arr[i]);
      if (reg_addr_i == ADDR_W'(ADR_CNT_BASE + i)) reg_rdata_o = cnt_arr[i];
    end
  end

  // R6
  ovf_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (ovf_vec != '0)) |=> ((status & $past(ovf_vec)) == $past(ovf_vec)));

  // R8
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == ADDR_W'(ADR_STATUS) && ovf_vec == '0)
      |=> (status == $past(status)));
endmodule

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;
  localparam int W = 48;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 0;
  logic         rst_n = 0;
  logic         up_en_i = 0;
  logic [7:0]   evt_i = '0;
  logic         reg_we_i = 0;
  logic [4:0]   reg_addr_i = '0;
  logic [W-1:0] reg_wdata_i = '0;
  logic [W-1:0] reg_rdata_o;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  perf_counter_bank i_perf_counter_bank (
    .clk(clk), .rst_n(rst_n), .up_en_i(up_en_i), .evt_i(evt_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we_i = 1; reg_addr_i = 5'(a); reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    @(negedge clk);
    reg_addr_i = 5'(a);
    #1 d = reg_rdata_o;
  endtask

  // hold evt pattern for n rising edges
  task automatic run(input logic [7:0] e, input int n);
    @(negedge clk);
    evt_i = e;
    repeat (n) @(negedge clk);
    evt_i = '0;
  endtask

  logic [W-1:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 24; a++) begin
      rd(a, v); chk("R1 reset value", v, '0);
    end
    chk("R1 irq after reset", W'(irq_o), '0);

    // R2 sweep: every counter, every enable combination
    for (int c = 0; c < 8; c++) begin
      for (int m = 0; m < 8; m++) begin
        wr(8 + c, W'((c << 1) | (m & 1)));
        wr(0, W'(((m >> 1) & 1) << c));
        wr(16 + c, '0);
        up_en_i = m[2];
        run(8'hFF, 5);
        up_en_i = 0;
        rd(16 + c, v);
        chk("R2 three-way enable", v, (m == 7) ? W'(5) : W'(0));
      end
    end
    wr(0, '0);

    // R3 event select sweep on counter 3
    up_en_i = 1;
    wr(0, W'(8'h08));
    for (int s = 0; s < 8; s++) begin
      wr(11, W'((s << 1) | 1));
      wr(19, '0);
      run(8'(1 << s), 3);
      run(~8'(1 << s), 4);
      rd(19, v);
      chk("R3 event select", v, W'(3));
    end

    // R8 direct counter access and write priority
    wr(19, 48'hA5A5_1234_5678);
    rd(19, v); chk("R8 counter readback", v, 48'hA5A5_1234_5678);
    @(negedge clk);
    evt_i = 8'h08;          // sel still 7 -> use counter 3 with sel 3
    wr(11, W'((3 << 1) | 1));
    wr(19, W'(100));        // event high on this edge: write wins
    evt_i = '0;
    rd(19, v); chk("R8 write beats increment", v, W'(100));

    // R4 wrap and status
    wr(0, W'(8'h20));
    wr(13, W'((5 << 1) | 1));
    wr(21, ONES - 1);
    run(8'h20, 2);
    rd(21, v); chk("R4 wrap to zero", v, '0);
    rd(1, v);  chk("R4 status set", v, W'(8'h20));
    chk("R7 irq off while disabled", W'(irq_o), '0);
    wr(13, W'(16 | (5 << 1) | 1));
    #1 chk("R7 irq on with enable", W'(irq_o), W'(1));

    // R8 status write ignored
    wr(1, '0);
    rd(1, v); chk("R8 status write ignored", v, W'(8'h20));

    // R5 clear register behaviour
    rd(2, v); chk("R5 clear reads zero", v, '0);
    wr(2, W'(8'hDF));
    rd(1, v); chk("R5 zero bits no effect", v, W'(8'h20));
    wr(2, W'(8'h20));
    rd(1, v); chk("R5 clear bit", v, '0);
    chk("R7 irq drops after clear", W'(irq_o), '0);

    // R6 overflow and clear on the same edge
    wr(21, ONES);
    @(negedge clk);
    evt_i = 8'h20; reg_we_i = 1; reg_addr_i = 5'(2); reg_wdata_i = W'(8'h20);
    @(negedge clk);
    evt_i = '0; reg_we_i = 0;
    rd(1, v);  chk("R6 overflow beats clear", v, W'(8'h20));
    rd(21, v); chk("R6 counter wrapped", v, '0);
    chk("R7 irq with status and enable", W'(irq_o), W'(1));

    up_en_i = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule